// File: doc/BRIEF.md
# Sleep-State Indicator Blink Controller

This block decides, for two open-drain indicator pins (a power lamp and a suspend lamp), whether each pin is released, held low, or pulsed at one of three slow rates. The decision follows the live 2-bit power-state code: each lamp owns a 10-bit setting made of five 2-bit match fields. Each field stands for one behaviour. A field whose value equals the current state code selects its behaviour, and a fixed priority resolves several matches.

All three blink rates are cut from one free-running counter advanced by a 4 Hz tick, so the slower waveforms change only where the 1 Hz one does. A shared invert bit flips the phase of every blink waveform without touching the steady behaviours. Software loads the two settings and the invert bit through a simple write port.

Internally each lamp has a small mode state machine with states RELEASED, BLINK_FAST (1 Hz), BLINK_MID (0.5 Hz), BLINK_SLOW (0.25 Hz) and HOLD_LOW. On every clock it moves from whatever state it holds to the state chosen by the highest-priority matching field, or to RELEASED when none matches. The transitions are named by their target: MATCH_RELEASE, MATCH_FAST, MATCH_MID, MATCH_SLOW, MATCH_LOW and NO_MATCH, and any state may take any of them. A second registered process turns the mode and the blink phases into the pin-low request.

Top module: `led_sleep_indicator`

## Requirements
- R1: During and right after reset both pins are released (`led_pull_low` = 00); the power lamp setting resets to 0x09B, the suspend lamp setting to 0x098, the invert bit to 1 and the blink counter to 0.
- R2: When bits 9:8 of a lamp's setting equal `pwr_state`, that lamp is released (`led_pull_low` bit = 0), whatever other fields match.
- R3: When bits 7:6 equal `pwr_state` (and R2 does not apply), the pin is pulled low exactly when bit 1 of the tick counter XOR the invert bit is 1: a 1 Hz, 50 % square wave.
- R4: When bits 5:4 are the highest-priority match, the pin follows bit 2 of the tick counter XOR the invert bit (0.5 Hz).
- R5: When bits 3:2 are the highest-priority match, the pin follows bit 3 of the tick counter XOR the invert bit (0.25 Hz).
- R6: When bits 1:0 are the only matching field, the pin is pulled low continuously.
- R7: When no field matches, the pin is released.
- R8: Match priority, highest first: bits 9:8, 7:6, 5:4, 3:2, 1:0.
- R9: The invert bit flips the phase of every blink rate on both lamps and has no effect on released or held-low pins.
- R10: A write with `cfg_addr` 0 loads the power lamp setting (bit 0 of `led_pull_low`), 1 the suspend lamp setting (bit 1), 2 loads the invert bit from `cfg_wdata[0]`; address 3 changes nothing.
- R11: A change of `pwr_state` shows at `led_pull_low` after two rising clock edges.
- R12: The tick counter advances by one on each clock edge with `tick_4hz` high, otherwise holds, and is never cleared by writes or state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_state | input | 2 | Current power-state code (11 full on, 10 suspend-to-RAM, 00 soft off, 01 reserved) |
| tick_4hz | input | 1 | One-cycle pulse at 4 Hz |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write target: 0 power setting, 1 suspend setting, 2 invert bit |
| cfg_wdata | input | 10 | Write data |
| led_pull_low | output | 2 | Per lamp: 1 pulls the open-drain pin low, 0 releases it |

## Verification
A mode machine stuck in, or decoding to, the wrong state shows at the pins within two clock edges of a state-code change: a steady level where a square wave is due, or the wrong steady level. A blink counter that drifts or restarts shows as a phase error at the next tick, because the bench keeps its own tick count through every write and state change and compares each lamp after every tick. A misdecoded write is caught at the first pin comparison following it, including the write to the unused address.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
    localparam int FIELD_W = 2;
    localparam int RATE_N  = 3;
    localparam int FIELD_N = RATE_N + 2;
    localparam int SET_W   = FIELD_W * FIELD_N;
    localparam int CNT_W   = RATE_N + 1;

    typedef enum logic [2:0] {
        MODE_RELEASED   = 3'd0,
        MODE_BLINK_FAST = 3'd1,
        MODE_BLINK_MID  = 3'd2,
        MODE_BLINK_SLOW = 3'd3,
        MODE_HOLD_LOW   = 3'd4
    } led_mode_e;
endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
    import led_blink_pkg::*;
#(
    parameter int                          NUM_LEDS  = 2,
    parameter int                          ADDR_W    = 2,
    parameter logic [NUM_LEDS*SET_W-1:0]   SET_RESET = {10'h098, 10'h09B},
    parameter logic                        INV_RESET = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [SET_W-1:0]          cfg_wdata,
    output logic [NUM_LEDS*SET_W-1:0] settings,
    output logic                      blink_inv
);
    localparam logic [ADDR_W-1:0] INV_ADDR = ADDR_W'(NUM_LEDS);

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                settings[i*SET_W +: SET_W] <= SET_RESET[i*SET_W +: SET_W];
            else if (cfg_we && cfg_addr == ADDR_W'(i))
                settings[i*SET_W +: SET_W] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            blink_inv <= INV_RESET;
        else if (cfg_we && cfg_addr == INV_ADDR)
            blink_inv <= cfg_wdata[0];
    end

    AST_UNUSED_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > INV_ADDR) |=> ($stable(settings) && $stable(blink_inv))); // R10
endmodule

// File: rtl/led_tick_divider.sv
module led_tick_divider
    import led_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              blink_inv,
    output logic [RATE_N-1:0] phase
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    for (genvar k = 0; k < RATE_N; k++) begin : g_phase
        assign phase[k] = cnt[k+1] ^ blink_inv;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(cnt) + 1'b1)); // R12
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R12
endmodule

// File: rtl/led_mode_fsm.sv
module led_mode_fsm
    import led_blink_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] pwr_state,
    input  logic [SET_W-1:0]   setting,
    input  logic [RATE_N-1:0]  phase,
    output logic               pin_low
);
    led_mode_e mode, mode_nxt;

    // Field 0 holds low, fields 1..RATE_N blink (slowest first),
    // top field releases. Higher fields override lower ones.
    function automatic led_mode_e field_mode(int f);
        if (f == 0)
            return MODE_HOLD_LOW;
        else if (f == FIELD_N - 1)
            return MODE_RELEASED;
        else
            return led_mode_e'(3'(int'(MODE_BLINK_FAST) + (RATE_N - f)));
    endfunction

    always_comb begin
        mode_nxt = MODE_RELEASED;
        for (int f = 0; f < FIELD_N; f++) begin
            if (setting[f*FIELD_W +: FIELD_W] == pwr_state)
                mode_nxt = field_mode(f);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode <= MODE_RELEASED;
        else
            mode <= mode_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pin_low <= 1'b0;
        else begin
            unique case (mode)
                MODE_RELEASED:   pin_low <= 1'b0;
                MODE_BLINK_FAST: pin_low <= phase[0];
                MODE_BLINK_MID:  pin_low <= phase[1];
                MODE_BLINK_SLOW: pin_low <= phase[2];
                MODE_HOLD_LOW:   pin_low <= 1'b1;
                default:         pin_low <= 1'b0;
            endcase
        end
    end

    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELEASED) |=> !pin_low); // R2
    AST_HOLD_LOW_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD_LOW) |=> pin_low); // R6
    AST_FAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BLINK_FAST) |=> (pin_low == $past(phase[0]))); // R3
    AST_TOP_FIELD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (setting[SET_W-1 -: FIELD_W] == pwr_state) |=> (mode == MODE_RELEASED)); // R8
endmodule

// File: rtl/led_sleep_indicator.sv
module led_sleep_indicator
    import led_blink_pkg::*;
#(
    parameter int                        NUM_LEDS  = 2,
    parameter int                        ADDR_W    = 2,
    parameter logic [NUM_LEDS*SET_W-1:0] SET_RESET = {10'h098, 10'h09B},
    parameter logic                      INV_RESET = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FIELD_W-1:0]  pwr_state,
    input  logic                tick_4hz,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [SET_W-1:0]    cfg_wdata,
    output logic [NUM_LEDS-1:0] led_pull_low
);
    logic [NUM_LEDS*SET_W-1:0] settings;
    logic                      blink_inv;
    logic [RATE_N-1:0]         phase;

    led_cfg_regs #(
        .NUM_LEDS (NUM_LEDS),
        .ADDR_W   (ADDR_W),
        .SET_RESET(SET_RESET),
        .INV_RESET(INV_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .settings (settings),
        .blink_inv(blink_inv)
    );

    led_tick_divider u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_4hz),
        .blink_inv(blink_inv),
        .phase    (phase)
    );

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        led_mode_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .pwr_state(pwr_state),
            .setting  (settings[i*SET_W +: SET_W]),
            .phase    (phase),
            .pin_low  (led_pull_low[i])
        );
    end

    AST_RESET_RELEASED: assert property (@(posedge clk)
        !rst_n |=> (led_pull_low == '0 || rst_n)); // R1
endmodule

// File: tb/led_sleep_indicator_test.sv
module led_sleep_indicator_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr_state = 2'b11;
    logic       tick_4hz = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [9:0] cfg_wdata = '0;
    logic [1:0] led_pull_low;

    always #4 clk = ~clk;

    led_sleep_indicator uut (
        .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .tick_4hz(tick_4hz),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .led_pull_low(led_pull_low)
    );

    typedef struct { int led; logic val; string tag; } item_t;
    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state kept by the bench
    logic [9:0] m_set [2];
    logic       m_inv;
    int         m_ticks;

    function automatic logic model_led(logic [9:0] s, logic [1:0] c, int t, logic inv);
        if (s[9:8] == c) return 1'b0;
        if (s[7:6] == c) return logic'((t >> 1) & 1) ^ inv;
        if (s[5:4] == c) return logic'((t >> 2) & 1) ^ inv;
        if (s[3:2] == c) return logic'((t >> 3) & 1) ^ inv;
        if (s[1:0] == c) return 1'b1;
        return 1'b0;
    endfunction

    // monitor: compares queued expectations just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (led_pull_low[it.led] !== it.val) begin
                    errors++;
                    $display("FAIL %s lamp%0d actual=%b expected=%b", it.tag, it.led,
                             led_pull_low[it.led], it.val);
                end
            end
        end
    end

    task automatic expect_val(int led, logic v, string tag);
        sb_q.push_back('{led, v, tag});
        @(posedge clk);
        #3;
    endtask

    task automatic expect_model(string tag);
        for (int i = 0; i < 2; i++)
            sb_q.push_back('{i, model_led(m_set[i], pwr_state, m_ticks, m_inv), tag});
        @(posedge clk);
        #3;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic write_cfg(logic [1:0] a, logic [9:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 2) m_set[a] = d;
        else if (a == 2) m_inv = d[0];
        settle();
    endtask

    task automatic set_state(logic [1:0] c);
        @(negedge clk);
        pwr_state = c;
        settle();
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_4hz = 1'b1;
        @(negedge clk);
        tick_4hz = 1'b0;
        m_ticks++;
    endtask

    task automatic sweep(int n, string tag);
        for (int k = 0; k < n; k++) begin
            tick_once();
            expect_model(tag);
        end
    endtask

    initial begin
        m_set[0] = 10'h09B;
        m_set[1] = 10'h098;
        m_inv = 1'b1;
        m_ticks = 0;
        repeat (3) @(negedge clk);
        expect_val(0, 1'b0, "R1 reset power");
        expect_val(1, 1'b0, "R1 reset suspend");
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        // state 11: power default holds low, suspend has no match
        expect_val(0, 1'b1, "R1 R6 default power in 11");
        expect_val(1, 1'b0, "R1 R7 default suspend in 11");
        // state 10: both blink 1 Hz; inverted default phase
        set_state(2'b10);
        expect_model("R3 R9 1Hz start");
        sweep(8, "R3 R12 1Hz sweep");
        // reserved code 01 matches bits 5:4 of both defaults
        set_state(2'b01);
        sweep(9, "R4 0.5Hz sweep");
        // state 00: top field of both defaults
        set_state(2'b00);
        expect_val(0, 1'b0, "R2 power released in 00");
        expect_val(1, 1'b0, "R2 suspend released in 00");
        sweep(3, "R2 released while ticking");
        // 0.25 Hz via bits 3:2 on the power lamp
        write_cfg(2'd0, 10'b01_01_01_00_01);
        sweep(17, "R5 R10 0.25Hz sweep");
        // priority: 7:6 beats 5:4, 3:2, 1:0
        write_cfg(2'd0, 10'b11_00_00_00_00);
        sweep(4, "R8 1Hz wins over lower fields");
        // all fields match: release wins
        write_cfg(2'd0, 10'b00_00_00_00_00);
        expect_val(0, 1'b0, "R8 top field wins");
        // 5:4 beats 3:2 and 1:0
        write_cfg(2'd0, 10'b11_11_00_00_00);
        sweep(5, "R8 0.5Hz wins over 0.25Hz");
        // invert cleared: blink phases flip, steady levels unchanged
        write_cfg(2'd2, 10'h000);
        set_state(2'b10);
        sweep(5, "R9 inverted phase");
        write_cfg(2'd0, 10'b11_11_11_11_10);
        expect_val(0, 1'b1, "R9 hold low ignores invert");
        // address 3 write must change nothing
        write_cfg(2'd3, 10'h3FF);
        expect_model("R10 unused address");
        sweep(3, "R10 unused address sweep");
        // latency: 00 (released for lamp0 setting below) -> 11 held low
        write_cfg(2'd0, 10'h09B);
        set_state(2'b00);
        expect_val(0, 1'b0, "R11 before change");
        @(negedge clk);
        pwr_state = 2'b11;
        expect_val(0, 1'b0, "R11 one edge after change");
        expect_val(0, 1'b1, "R11 two edges after change");
        settle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule